// File: doc/BRIEF.md
# Pixel Stream Timing Generator

This block produces the control pattern of a raster pixel stream from a set of timing settings. The settings are the total and active slots per line, the two porches, the total lines per frame, and the first and last active lines. On each clock it advances one pixel slot. It marks the active region with five strobes: line start, line end, frame start, frame end and pixel valid. It also copies an incoming pixel to the output on active slots and forces the output data to zero everywhere else.

The block serves as a stimulus source and as a format shaper for pixel-processing pipelines. Such pipelines need a known number of idle cycles between lines and idle lines between frames. Within a line, the back porch comes first, then the active pixels, then the front porch. A consistency check runs against the settings on every cycle. A bad set of settings raises a sticky error flag, and while that flag is raised the block marks no slot as active.

Top module: `pix_timing_gen`

## Requirements
- R1: After reset, every output is low, pixOut is zero and the slot counters are at line 0, slot 0. No slot is generated until `enable` is sampled high. From then on, slots run back to back, one per clock, whatever `enable` does afterwards.
- R2: Each line lasts cfgTotalPix clocks. The first cfgBackPorch slots are idle, the next cfgActivePix slots are active, and the last cfgFrontPorch slots are idle. validO is high only on active slots of active lines.
- R3: Each frame has cfgTotalLines lines. Only the lines from cfgFirstLine through cfgLastLine, both included, carry valid slots.
- R4: hStartO pulses on the first active slot of every active line, and hEndO pulses on the last active slot of every active line.
- R5: vStartO pulses together with hStartO on line cfgFirstLine only. vEndO pulses together with hEndO on line cfgLastLine only.
- R6: No start or end strobe is ever high while validO is low.
- R7: Outputs appear one clock after their slot. pixOut equals the pixIn presented during that slot when the slot is valid, and is zero otherwise.
- R8: Each active line has exactly cfgTotalPix - cfgActivePix idle clocks. Each frame has exactly cfgTotalLines - (cfgLastLine - cfgFirstLine + 1) lines without any valid slot. For example, 140 idle clocks per line and 80 idle lines per frame.
- R9: paramErr rises when any of these holds: cfgFrontPorch + cfgBackPorch differs from cfgTotalPix - cfgActivePix; cfgActivePix is zero; cfgActivePix exceeds cfgTotalPix; cfgFirstLine exceeds cfgLastLine; cfgLastLine is not below cfgTotalLines. While paramErr is high, validO, all strobes and pixOut stay low.
- R10: paramErr stays high until reset, even after the settings are corrected.
- R11: Zero horizontal blanking is legal: with cfgActivePix equal to cfgTotalPix and both porches zero, every slot of an active line is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Starts slot generation when first seen high |
| cfgTotalPix | input | H_W | Slots per line |
| cfgActivePix | input | H_W | Active slots per line |
| cfgFrontPorch | input | H_W | Idle slots after the active region |
| cfgBackPorch | input | H_W | Idle slots before the active region |
| cfgTotalLines | input | V_W | Lines per frame |
| cfgFirstLine | input | V_W | Index of the first active line |
| cfgLastLine | input | V_W | Index of the last active line |
| pixIn | input | PIX_W | Pixel data for the current slot |
| pixOut | output | PIX_W | Pixel data, zero when not valid |
| hStartO | output | 1 | First active slot of a line |
| hEndO | output | 1 | Last active slot of a line |
| vStartO | output | 1 | First active slot of a frame |
| vEndO | output | 1 | Last active slot of a frame |
| validO | output | 1 | Active slot |
| paramErr | output | 1 | Sticky settings error |

## Verification
Some relations hold on every cycle, and the assertions check those. Strobes only appear with validO. Frame strobes only appear with the matching line strobe. Data is zero off valid slots. No valid slot appears under an error, and the error flag never falls. Other behaviour depends on where a pulse lands inside the line and the frame, and only the bench scenarios can show it. This covers the porch order, the inclusive range of active lines, the idle counts per line and per frame, the wait for enable and the zero-blanking corner. The bench compares each slot against its own model of the raster.

// File: rtl/pix_timing_pkg.sv
package pix_timing_pkg;

  // Per-slot strobes handed from the control to the datapath
  typedef struct packed {
    logic hStart;
    logic hEnd;
    logic vStart;
    logic vEnd;
    logic valid;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{default: 1'b0};

endpackage

// File: rtl/pix_timing_ctrl.sv
module pix_timing_ctrl
  import pix_timing_pkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 12
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           enable,
  input  logic [H_W-1:0] cfgTotalPix,
  input  logic [H_W-1:0] cfgActivePix,
  input  logic [H_W-1:0] cfgFrontPorch,
  input  logic [H_W-1:0] cfgBackPorch,
  input  logic [V_W-1:0] cfgTotalLines,
  input  logic [V_W-1:0] cfgFirstLine,
  input  logic [V_W-1:0] cfgLastLine,
  output strobe_t        strobe,
  output logic           paramErr
);

  localparam int HS_W = H_W + 1;

  logic           running;
  logic           errSticky;
  logic           errNow;
  logic [H_W-1:0] pixCnt;
  logic [V_W-1:0] lineCnt;
  logic           lastPix;
  logic           lastLine;
  logic [HS_W-1:0] porchSum;
  logic [HS_W-1:0] blankSpan;
  logic [H_W-1:0] colOff;
  logic           colAct;
  logic           rowAct;
  logic           slotOn;

  // Settings consistency, evaluated every cycle
  always_comb begin
    porchSum  = HS_W'(cfgFrontPorch) + HS_W'(cfgBackPorch);
    blankSpan = HS_W'(cfgTotalPix) - HS_W'(cfgActivePix);
    errNow    = (porchSum != blankSpan)
             || (cfgActivePix == '0)
             || (cfgActivePix > cfgTotalPix)
             || (cfgFirstLine > cfgLastLine)
             || (cfgLastLine >= cfgTotalLines);
  end

  assign lastPix  = (pixCnt >= cfgTotalPix - H_W'(1));
  assign lastLine = (lineCnt >= cfgTotalLines - V_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      errSticky <= 1'b0;
      pixCnt    <= '0;
      lineCnt   <= '0;
    end else begin
      errSticky <= errSticky | errNow;
      if (!running) begin
        running <= enable;
      end else if (lastPix) begin
        pixCnt  <= '0;
        lineCnt <= lastLine ? '0 : lineCnt + V_W'(1);
      end else begin
        pixCnt <= pixCnt + H_W'(1);
      end
    end
  end

  // Position decode: back porch, active region, front porch
  always_comb begin
    colOff = pixCnt - cfgBackPorch;
    colAct = (pixCnt >= cfgBackPorch) && (colOff < cfgActivePix);
    rowAct = (lineCnt >= cfgFirstLine) && (lineCnt <= cfgLastLine);
    slotOn = running && !errNow && !errSticky && colAct && rowAct;

    strobe        = STROBE_IDLE;
    strobe.valid  = slotOn;
    strobe.hStart = slotOn && (colOff == '0);
    strobe.hEnd   = slotOn && (colOff == cfgActivePix - H_W'(1));
    strobe.vStart = strobe.hStart && (lineCnt == cfgFirstLine);
    strobe.vEnd   = strobe.hEnd && (lineCnt == cfgLastLine);
  end

  assign paramErr = errSticky;

endmodule

// File: rtl/pix_timing_dp.sv
module pix_timing_dp
  import pix_timing_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [PIX_W-1:0] pixIn,
  output strobe_t          strobeQ,
  output logic [PIX_W-1:0] pixOut
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeQ <= STROBE_IDLE;
      pixOut  <= '0;
    end else begin
      strobeQ <= strobe;
      pixOut  <= strobe.valid ? pixIn : '0;
    end
  end

endmodule

// File: rtl/pix_timing_gen.sv
module pix_timing_gen
  import pix_timing_pkg::*;
#(
  parameter int H_W   = 12,
  parameter int V_W   = 12,
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [H_W-1:0]   cfgTotalPix,
  input  logic [H_W-1:0]   cfgActivePix,
  input  logic [H_W-1:0]   cfgFrontPorch,
  input  logic [H_W-1:0]   cfgBackPorch,
  input  logic [V_W-1:0]   cfgTotalLines,
  input  logic [V_W-1:0]   cfgFirstLine,
  input  logic [V_W-1:0]   cfgLastLine,
  input  logic [PIX_W-1:0] pixIn,
  output logic [PIX_W-1:0] pixOut,
  output logic             hStartO,
  output logic             hEndO,
  output logic             vStartO,
  output logic             vEndO,
  output logic             validO,
  output logic             paramErr
);

  strobe_t strobe;
  strobe_t strobeQ;

  pix_timing_ctrl #(.H_W(H_W), .V_W(V_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .cfgTotalPix  (cfgTotalPix),
    .cfgActivePix (cfgActivePix),
    .cfgFrontPorch(cfgFrontPorch),
    .cfgBackPorch (cfgBackPorch),
    .cfgTotalLines(cfgTotalLines),
    .cfgFirstLine (cfgFirstLine),
    .cfgLastLine  (cfgLastLine),
    .strobe       (strobe),
    .paramErr     (paramErr)
  );

  pix_timing_dp #(.PIX_W(PIX_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .pixIn  (pixIn),
    .strobeQ(strobeQ),
    .pixOut (pixOut)
  );

  assign hStartO = strobeQ.hStart;
  assign hEndO   = strobeQ.hEnd;
  assign vStartO = strobeQ.vStart;
  assign vEndO   = strobeQ.vEnd;
  assign validO  = strobeQ.valid;

endmodule

// File: rtl/pix_timing_gen_checker.sv
module pix_timing_gen_checker #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [PIX_W-1:0] pixOut,
  input logic             hStartO,
  input logic             hEndO,
  input logic             vStartO,
  input logic             vEndO,
  input logic             validO,
  input logic             paramErr
);

  // R6: line strobes only on valid slots
  p_hstart_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    hStartO |-> validO);
  p_hend_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    hEndO |-> validO);

  // R5: frame strobes ride on the matching line strobe
  p_vstart_hstart_r5: assert property (@(posedge clk) disable iff (!rstN)
    vStartO |-> hStartO);
  p_vend_hend_r5: assert property (@(posedge clk) disable iff (!rstN)
    vEndO |-> hEndO);

  // R7: data is zero off valid slots
  p_blank_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    !validO |-> (pixOut == '0));

  // R9: no valid slot under a settings error
  p_err_mutes_r9: assert property (@(posedge clk) disable iff (!rstN)
    paramErr |-> !validO);

  // R10: error flag never falls before reset
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    paramErr |=> paramErr);

endmodule

bind pix_timing_gen pix_timing_gen_checker #(.PIX_W(PIX_W)) u_checker (
  .clk     (clk),
  .rstN    (rstN),
  .pixOut  (pixOut),
  .hStartO (hStartO),
  .hEndO   (hEndO),
  .vStartO (vStartO),
  .vEndO   (vEndO),
  .validO  (validO),
  .paramErr(paramErr)
);

// File: tb/pix_timing_gen_bench.sv
module pix_timing_gen_bench;

  localparam int H_W   = 12;
  localparam int V_W   = 12;
  localparam int PIX_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic [H_W-1:0]   cfgTotalPix, cfgActivePix, cfgFrontPorch, cfgBackPorch;
  logic [V_W-1:0]   cfgTotalLines, cfgFirstLine, cfgLastLine;
  logic [PIX_W-1:0] pixIn = '0;
  logic [PIX_W-1:0] pixOut;
  logic             hStartO, hEndO, vStartO, vEndO, validO, paramErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pix_timing_gen #(.H_W(H_W), .V_W(V_W), .PIX_W(PIX_W)) u_pix_timing_gen (
    .clk, .rstN, .enable,
    .cfgTotalPix, .cfgActivePix, .cfgFrontPorch, .cfgBackPorch,
    .cfgTotalLines, .cfgFirstLine, .cfgLastLine,
    .pixIn, .pixOut,
    .hStartO, .hEndO, .vStartO, .vEndO, .validO, .paramErr
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [PIX_W-1:0] pinOf(input int s);
    return {1'b1, 7'(s)};
  endfunction

  task automatic setCfg(input int tp, input int ap, input int fp, input int bp,
                        input int tl, input int fl, input int ll);
    cfgTotalPix   = H_W'(tp);
    cfgActivePix  = H_W'(ap);
    cfgFrontPorch = H_W'(fp);
    cfgBackPorch  = H_W'(bp);
    cfgTotalLines = V_W'(tl);
    cfgFirstLine  = V_W'(fl);
    cfgLastLine   = V_W'(ll);
  endtask

  task automatic doReset();
    enable = 1'b0;
    rstN   = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Starts the generator and compares nSlots slots to the raster model.
  // errMode: expect everything muted.
  task automatic runSlots(input int nSlots, input bit errMode, input string tag);
    int tp = int'(cfgTotalPix);
    int ap = int'(cfgActivePix);
    int bp = int'(cfgBackPorch);
    int tl = int'(cfgTotalLines);
    int fl = int'(cfgFirstLine);
    int ll = int'(cfgLastLine);
    int idleInLine = 0;
    int validInLine = 0;
    int blankLines = 0;
    int badIdle = 0;
    int linesSeen = 0;
    int expBlank = tl - (ll - fl + 1);
    int mism = 0;
    pixIn  = pinOf(0);
    enable = 1'b1;
    @(posedge clk);
    @(negedge clk);
    enable = 1'b0;  // R1: generation continues without enable
    for (int k = 1; k <= nSlots; k++) begin
      @(posedge clk);
      @(negedge clk);
      begin
        int s = k - 1;
        int x = s % tp;
        int y = (s / tp) % tl;
        bit v  = !errMode && x >= bp && x < bp + ap && y >= fl && y <= ll;
        bit hs = v && x == bp;
        bit he = v && x == bp + ap - 1;
        bit vs = hs && y == fl;
        bit ve = he && y == ll;
        logic [PIX_W-1:0] ep = v ? pinOf(s) : '0;
        if (validO !== v || hStartO !== hs || hEndO !== he ||
            vStartO !== vs || vEndO !== ve || pixOut !== ep) begin
          mism++;
          if (mism <= 4)
            $display("FAIL R2/R3/R4/R5/R7 %s slot %0d actual=%0b%0b%0b%0b%0b/%0d expected=%0b%0b%0b%0b%0b/%0d",
                     tag, s, validO, hStartO, hEndO, vStartO, vEndO, pixOut,
                     v, hs, he, vs, ve, ep);
        end
        if (validO) validInLine++; else idleInLine++;
        if (x == tp - 1) begin
          if (validInLine == 0) blankLines++;
          else if (idleInLine != tp - ap) badIdle++;
          linesSeen++;
          validInLine = 0;
          idleInLine  = 0;
        end
      end
      pixIn = pinOf(k);
    end
    nChecks++;
    if (mism != 0) begin
      nFails++;
      $display("FAIL R2 %s slot mismatches actual=%0d expected=0", tag, mism);
    end
    if (!errMode && nSlots >= tp * tl) begin
      // R8: idle clocks per active line and idle lines per frame
      check(badIdle == 0, "R8 idle clocks per line", badIdle, 0);
      check(blankLines == expBlank * (linesSeen / tl), "R8 idle lines per frame",
            blankLines, expBlank * (linesSeen / tl));
    end
  endtask

  task automatic tReset();
    setCfg(10, 6, 1, 3, 6, 1, 4);
    doReset();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(!validO && !hStartO && !hEndO && !vStartO && !vEndO && pixOut == '0,
            "R1 idle before enable", int'(validO), 0);
    end
    check(!paramErr, "R1 no error after reset", int'(paramErr), 0);
  endtask

  task automatic tSmallFrames();
    setCfg(10, 6, 1, 3, 6, 1, 4);
    doReset();
    runSlots(2 * 60, 1'b0, "small");
  endtask

  task automatic tWideBlank();
    // 140 idle clocks per line, 80 idle lines per frame
    setCfg(160, 20, 60, 80, 84, 30, 33);
    doReset();
    runSlots(160 * 84, 1'b0, "wide");
  endtask

  task automatic tNoHBlank();
    setCfg(5, 5, 0, 0, 4, 0, 3);
    doReset();
    runSlots(2 * 20, 1'b0, "R11 zero blanking");
  endtask

  task automatic tParamErr();
    setCfg(10, 6, 2, 3, 6, 1, 4);  // porch sum 5, span 4
    doReset();
    check(paramErr, "R9 porch mismatch flagged", int'(paramErr), 1);
    runSlots(60, 1'b1, "R9 muted");
    setCfg(10, 6, 1, 3, 6, 1, 4);
    runSlots(60, 1'b1, "R10 still muted");
    check(paramErr, "R10 flag sticky", int'(paramErr), 1);
    setCfg(10, 6, 1, 3, 6, 4, 1);  // first above last
    doReset();
    check(paramErr, "R9 line order flagged", int'(paramErr), 1);
    setCfg(10, 6, 1, 3, 6, 1, 6);  // last not below total
    doReset();
    check(paramErr, "R9 last line range flagged", int'(paramErr), 1);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    tReset();
    tSmallFrames();
    tWideBlank();
    tNoHBlank();
    tParamErr();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule